// File: doc/BRIEF.md
# DDR SDRAM Command Decoder

This block watches the command pins of a four-bank double-data-rate SDRAM model and turns each rising-edge sample into a one-hot command strobe with its fields already pulled apart. The fields are bank, row, column, auto-precharge request, precharge-all request, mode-register target and opcode. Next to these strobes it tracks which banks hold an open row, and it runs a small burst counter. With that state it flags commands that are not legal at the moment they arrive, and it reports the write-mask pin for each data cycle of a write burst.

Every output is registered. A command sampled at edge k appears on the outputs after edge k and stays there for one clock. A command flagged as illegal is still reported on its strobe, but it changes neither the bank state nor the burst state. The data-bus organisation (x4, x8, x16) is a parameter and picks the column bit mapping.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: With cs_n high the cycle decodes as NOP, exactly like cs_n low with ras_n/cas_n/we_n = 1,1,1. With cs_n low, {ras_n,cas_n,we_n} = 011 ACT, 101 READ, 100 WRITE, 110 BURST STOP, 010 PRECHARGE, 001 REFRESH, 000 MODE SET. cmd_o is one-hot with bit 0 NOP, 1 ACT, 2 READ, 3 WRITE, 4 BURST STOP, 5 PRECHARGE, 6 AUTO REFRESH, 7 SELF REFRESH, 8 MODE SET. cmd_o appears one clock after the sampling edge.
- R2: ACT reports bank_o = ba and row_o = addr[12:0]. row_o is zero for every other command.
- R3: READ and WRITE report bank_o = ba and col_o = {addr[11], addr[9:0]} for x4, addr[9:0] for x8 and addr[8:0] for x16. col_o is zero for every other command.
- R4: ap_o equals addr[10] on READ/WRITE only. It is zero on every other cycle and does not carry over to later commands.
- R5: PRECHARGE with addr[10] low closes bank ba and reports it on bank_o. With addr[10] high it closes all banks, sets pre_all_o and reports bank_o = 0 whatever ba holds.
- R6: The REFRESH code decodes as AUTO REFRESH when cke is high and as SELF REFRESH when cke is low. Any other non-NOP command with cke low raises illegal_o.
- R7: MODE SET reports opcode_o = addr[12:0]. mr_ext_o is set for ba = 01, and ba = 00 is the base register. ba = 10 or 11 raises mr_err_o.
- R8: BURST STOP is legal only while a READ burst without auto-precharge runs. In any other case (idle, during a write burst, during an auto-precharge read) it raises illegal_o. A legal BURST STOP ends the burst.
- R9: Each clock of a WRITE burst, starting the cycle after the WRITE strobe, sets wbeat_o. In the same cycle wmask_o carries dm as sampled at that edge (high means inhibit). Both are low outside write bursts.
- R10: ACT to an open bank, and READ/WRITE to a closed bank, raise illegal_o. ACT opens the bank.
- R11: A base MODE SET with addr[2:0] = 001/010/011 sets burst length 2/4/8. A burst then lasts 1/2/4 clocks. Other codes keep the prior length, and the reset length is 2. A new READ/WRITE restarts the count.
- R12: When an auto-precharge burst runs to its last clock without being restarted, its bank closes at that edge.
- R13: REFRESH or MODE SET while any bank is open raises illegal_o. Flags last one clock per offending command. Synchronous reset (rst_n low) zeroes every output and closes all banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus |
| dm | input | 1 | Write data mask |
| cmd_o | output | 9 | One-hot decoded command |
| bank_o | output | 2 | Decoded bank |
| row_o | output | 13 | Row on ACT |
| col_o | output | 11 | Column on READ/WRITE (x4 default) |
| ap_o | output | 1 | Auto-precharge request |
| pre_all_o | output | 1 | Precharge of all banks |
| mr_ext_o | output | 1 | Extended mode register selected |
| opcode_o | output | 13 | Mode register opcode |
| illegal_o | output | 1 | Command illegal in present state |
| mr_err_o | output | 1 | Reserved mode register selected |
| wbeat_o | output | 1 | Write data cycle in progress |
| wmask_o | output | 1 | Write mask for that data cycle |

## Verification
The assertions inside the trackers assume that only one command arrives per clock. Under that assumption an open request and a close request, or a burst start and a burst-length write, never meet in the same cycle, and the legality gate guarantees this. The assertions also assume the input pins are steady around the rising edge. The stimulus drives every pin at the falling edge and issues one command or NOP per clock. It stays within the column bits the x4 default maps, and it lowers cke only for NOP, self refresh, or a command that is meant to be rejected.

// File: rtl/ddr_cmd_pkg.sv
// Shared command codes and helpers for the DDR command decoder.
// Assumes a one-hot command vector indexed by cmd_e.
package ddr_cmd_pkg;
    localparam int unsigned NCMD = 9;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_BST  = 4'd4,
        CMD_PRE  = 4'd5,
        CMD_AREF = 4'd6,
        CMD_SREF = 4'd7,
        CMD_MRS  = 4'd8
    } cmd_e;

    // Column width for a given data-bus organisation (x4, x8, x16).
    function automatic int unsigned col_bits(input int unsigned org);
        case (org)
            4:       return 11;
            8:       return 10;
            default: return 9;
        endcase
    endfunction
endpackage

// File: rtl/ddr_cmd_classify.sv
// Combinational decode of the command pins into a command code and a
// column field. Assumes AW >= 13 and COLW == col_bits(ORG).
module ddr_cmd_classify
    import ddr_cmd_pkg::*;
#(
    parameter int unsigned ORG  = 4,
    parameter int unsigned AW   = 13,
    parameter int unsigned COLW = 11
) (
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [AW-1:0]   addr,
    output cmd_e            cmd,
    output logic [COLW-1:0] col
);
    // Map the strobe pattern to a command; deselect folds into NOP.
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end

    // Column bit selection picked by organisation; A10 is never a column bit.
    generate
        if (ORG == 4) begin : g_x4
            assign col = {addr[11], addr[9:0]};
        end else if (ORG == 8) begin : g_x8
            assign col = addr[9:0];
        end else begin : g_x16
            assign col = addr[8:0];
        end
    endgenerate
endmodule

// File: rtl/ddr_bank_tracker.sv
// Holds one open/closed bit per bank. Opens on an accepted activate,
// closes on an accepted precharge (single or all) or on auto-precharge
// completion. Assumes the caller never opens and closes the same bank
// in one cycle.
module ddr_bank_tracker #(
    parameter int unsigned BAW   = 2,
    localparam int unsigned NBANK = 1 << BAW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [BAW-1:0]   set_bank,
    input  logic             clr_en,
    input  logic             clr_all,
    input  logic [BAW-1:0]   clr_bank,
    input  logic             ap_clr,
    input  logic [BAW-1:0]   ap_bank,
    output logic [NBANK-1:0] open_q
);
    logic [NBANK-1:0] open_d;

    // Next-state of the open vector from this cycle's requests.
    always_comb begin
        open_d = open_q;
        if (set_en) open_d[set_bank] = 1'b1;
        if (clr_en) begin
            if (clr_all) open_d = '0;
            else         open_d[clr_bank] = 1'b0;
        end
        if (ap_clr) open_d[ap_bank] = 1'b0;
    end

    // Register the open vector; reset closes every bank.
    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= '0;
        else        open_q <= open_d;
    end

    // R10
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> open_q[$past(set_bank)]);
    // R5
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_all) |=> (open_q == '0));
    // R12
    ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_clr |=> !open_q[$past(ap_bank)]);
endmodule

// File: rtl/ddr_burst_tracker.sv
// Counts the clocks of the current read or write burst and holds the
// programmed burst length. Reports write data cycles, whether a burst stop
// is allowed, and the clock on which an auto-precharge burst completes.
// Assumes start, stop and bl_wr are mutually exclusive.
module ddr_burst_tracker #(
    parameter int unsigned BAW    = 2,
    parameter int unsigned MAX_BL = 8,
    localparam int unsigned MAXC  = MAX_BL / 2,
    localparam int unsigned CW    = $clog2(MAXC + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           start_rd,
    input  logic           start_ap,
    input  logic [BAW-1:0] start_bank,
    input  logic           stop,
    input  logic           bl_wr,
    input  logic [2:0]     bl_code,
    output logic           rd_noap,
    output logic           wbeat,
    output logic           ap_done,
    output logic [BAW-1:0] ap_bank
);
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  bl_q;
    logic [CW-1:0]  bl_new;
    logic           bl_ok;
    logic           rd_q;
    logic           ap_q;
    logic           busy;

    // Translate the burst-length code into clocks per burst.
    always_comb begin
        bl_ok  = 1'b1;
        bl_new = bl_q;
        case (bl_code)
            3'd1:    bl_new = CW'(1);
            3'd2:    bl_new = CW'(2);
            3'd3:    bl_new = CW'(4);
            default: bl_ok  = 1'b0;
        endcase
    end

    assign busy    = (cnt_q != '0);
    assign rd_noap = busy && rd_q && !ap_q;
    assign wbeat   = busy && !rd_q;
    assign ap_done = busy && (cnt_q == CW'(1)) && ap_q && !start && !stop;
    assign ap_bank = start_bank_q;

    logic [BAW-1:0] start_bank_q;

    // Burst length register and burst counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_q         <= CW'(1);
            cnt_q        <= '0;
            rd_q         <= 1'b0;
            ap_q         <= 1'b0;
            start_bank_q <= '0;
        end else begin
            if (bl_wr && bl_ok) bl_q <= bl_new;
            if (start) begin
                cnt_q        <= bl_q;
                rd_q         <= start_rd;
                ap_q         <= start_ap;
                start_bank_q <= start_bank;
            end else if (stop) begin
                cnt_q <= '0;
            end else if (busy) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    // R11
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAXC));
    // R11
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == $past(bl_q)));
    // R8
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !busy);
endmodule

// File: rtl/ddr_cmd_decoder.sv
// Top of the DDR command decoder. Samples the command pins every rising
// edge, judges legality against bank and burst state, updates that state
// only for legal commands and registers all outputs (one clock latency).
// Assumes BAW >= 2 and AW >= 13.
module ddr_cmd_decoder
    import ddr_cmd_pkg::*;
#(
    parameter int unsigned ORG    = 4,
    parameter int unsigned AW     = 13,
    parameter int unsigned BAW    = 2,
    parameter int unsigned MAX_BL = 8,
    localparam int unsigned COLW  = col_bits(ORG),
    localparam int unsigned NBANK = 1 << BAW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BAW-1:0]  ba,
    input  logic [AW-1:0]   addr,
    input  logic            dm,
    output logic [NCMD-1:0] cmd_o,
    output logic [BAW-1:0]  bank_o,
    output logic [AW-1:0]   row_o,
    output logic [COLW-1:0] col_o,
    output logic            ap_o,
    output logic            pre_all_o,
    output logic            mr_ext_o,
    output logic [AW-1:0]   opcode_o,
    output logic            illegal_o,
    output logic            mr_err_o,
    output logic            wbeat_o,
    output logic            wmask_o
);
    cmd_e             cmd;
    logic [COLW-1:0]  col;
    logic [NBANK-1:0] open_q;
    logic             bt_rd_noap;
    logic             bt_wbeat;
    logic             bt_ap_done;
    logic [BAW-1:0]   bt_ap_bank;
    logic             is_act, is_rd, is_wr, is_bst, is_pre, is_ref, is_mrs;
    logic             illegal;
    logic             go;
    logic [NCMD-1:0]  cmd_vec;

    ddr_cmd_classify #(.ORG(ORG), .AW(AW), .COLW(COLW)) i_classify (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .addr  (addr),
        .cmd   (cmd),
        .col   (col)
    );

    assign is_act  = (cmd == CMD_ACT);
    assign is_rd   = (cmd == CMD_RD);
    assign is_wr   = (cmd == CMD_WR);
    assign is_bst  = (cmd == CMD_BST);
    assign is_pre  = (cmd == CMD_PRE);
    assign is_ref  = (cmd == CMD_AREF) || (cmd == CMD_SREF);
    assign is_mrs  = (cmd == CMD_MRS);
    assign cmd_vec = NCMD'(1) << cmd;

    // Legality of the sampled command against clock enable, banks and burst.
    always_comb begin
        illegal = 1'b0;
        if (!cke && (cmd != CMD_NOP) && (cmd != CMD_SREF)) illegal = 1'b1;
        if (is_act && open_q[ba])                          illegal = 1'b1;
        if ((is_rd || is_wr) && !open_q[ba])               illegal = 1'b1;
        if (is_bst && !bt_rd_noap)                         illegal = 1'b1;
        if ((is_ref || is_mrs) && (|open_q))               illegal = 1'b1;
    end
    assign go = !illegal;

    ddr_bank_tracker #(.BAW(BAW)) i_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (go && is_act),
        .set_bank (ba),
        .clr_en   (go && is_pre),
        .clr_all  (addr[10]),
        .clr_bank (ba),
        .ap_clr   (bt_ap_done),
        .ap_bank  (bt_ap_bank),
        .open_q   (open_q)
    );

    ddr_burst_tracker #(.BAW(BAW), .MAX_BL(MAX_BL)) i_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (go && (is_rd || is_wr)),
        .start_rd   (is_rd),
        .start_ap   (addr[10]),
        .start_bank (ba),
        .stop       (go && is_bst),
        .bl_wr      (go && is_mrs && (ba == '0)),
        .bl_code    (addr[2:0]),
        .rd_noap    (bt_rd_noap),
        .wbeat      (bt_wbeat),
        .ap_done    (bt_ap_done),
        .ap_bank    (bt_ap_bank)
    );

    // Output register: strobes, decoded fields, flags and write mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o     <= '0;
            bank_o    <= '0;
            row_o     <= '0;
            col_o     <= '0;
            ap_o      <= 1'b0;
            pre_all_o <= 1'b0;
            mr_ext_o  <= 1'b0;
            opcode_o  <= '0;
            illegal_o <= 1'b0;
            mr_err_o  <= 1'b0;
            wbeat_o   <= 1'b0;
            wmask_o   <= 1'b0;
        end else begin
            cmd_o     <= cmd_vec;
            bank_o    <= (is_act || is_rd || is_wr || (is_pre && !addr[10])) ? ba : '0;
            row_o     <= is_act ? addr : '0;
            col_o     <= (is_rd || is_wr) ? col : '0;
            ap_o      <= (is_rd || is_wr) && addr[10];
            pre_all_o <= is_pre && addr[10];
            mr_ext_o  <= is_mrs && (ba == BAW'(1));
            opcode_o  <= is_mrs ? addr : '0;
            illegal_o <= illegal;
            mr_err_o  <= is_mrs && (|ba[BAW-1:1]);
            wbeat_o   <= bt_wbeat;
            wmask_o   <= bt_wbeat && dm;
        end
    end

    // R1
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_o));
    // R4
    ap_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_o |-> (cmd_o[CMD_RD] || cmd_o[CMD_WR]));
    // R5
    pall_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all_o |-> (cmd_o[CMD_PRE] && (bank_o == '0)));
    // R6
    sref_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o[CMD_SREF] |-> !$past(cke));
    // R7
    mrerr_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mr_err_o |-> cmd_o[CMD_MRS]);
    // R9
    wmask_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wmask_o |-> wbeat_o);
endmodule

// File: tb/test_ddr_cmd_decoder.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one command per clock at the
// falling edge and pushes the expected output word; the monitor pops and
// compares one clock later, after the rising edge.
module test_ddr_cmd_decoder;
    localparam logic [2:0] K_NOP = 3'b111, K_ACT = 3'b011, K_RD  = 3'b101,
                           K_WR  = 3'b100, K_BST = 3'b110, K_PRE = 3'b010,
                           K_REF = 3'b001, K_MRS = 3'b000;

    typedef struct packed {
        logic [8:0]  cmd;
        logic [1:0]  bank;
        logic [12:0] row;
        logic [10:0] col;
        logic        ap;
        logic        pall;
        logic        mrext;
        logic [12:0] opc;
        logic        ill;
        logic        mrerr;
        logic        wbeat;
        logic        wmask;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dm = 1'b0;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [8:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [12:0] row_o, opcode_o;
    logic [10:0] col_o;
    logic ap_o, pre_all_o, mr_ext_o, illegal_o, mr_err_o, wbeat_o, wmask_o;

    int checks = 0;
    int bad = 0;
    bit done = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    // reference state
    logic [3:0] m_open = '0;
    int         m_blc = 1;
    int         m_cnt = 0;
    logic       m_rd = 0, m_ap = 0;
    logic [1:0] m_bank = '0;

    always #5 clk = ~clk;

    ddr_cmd_decoder i_ddr_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dm(dm),
        .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
        .ap_o(ap_o), .pre_all_o(pre_all_o), .mr_ext_o(mr_ext_o),
        .opcode_o(opcode_o), .illegal_o(illegal_o), .mr_err_o(mr_err_o),
        .wbeat_o(wbeat_o), .wmask_o(wmask_o)
    );

    // Drive one clock of pins and push the expected outputs.
    task automatic step(input logic ck, input logic csn, input logic [2:0] rcw,
                        input logic [1:0] b, input logic [12:0] a, input logic m,
                        input string tag);
        int   ci;
        exp_t e;
        @(negedge clk);
        cke = ck; cs_n = csn; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a; dm = m;
        if (csn) ci = 0;
        else case (rcw)
            K_ACT: ci = 1;  K_RD: ci = 2;  K_WR: ci = 3;  K_BST: ci = 4;
            K_PRE: ci = 5;  K_REF: ci = ck ? 6 : 7;  K_MRS: ci = 8;
            default: ci = 0;
        endcase
        e = '0;
        e.cmd[ci] = 1'b1;
        if (ci == 1) begin e.bank = b; e.row = a; end
        if (ci == 2 || ci == 3) begin e.bank = b; e.col = {a[11], a[9:0]}; e.ap = a[10]; end
        if (ci == 5) begin e.pall = a[10]; e.bank = a[10] ? 2'd0 : b; end
        if (ci == 8) begin e.opc = a; e.mrext = (b == 2'b01); e.mrerr = b[1]; end
        e.ill = (!ck && ci != 0 && ci != 7) || (ci == 1 && m_open[b]) ||
                ((ci == 2 || ci == 3) && !m_open[b]) ||
                (ci == 4 && !(m_cnt > 0 && m_rd && !m_ap)) ||
                ((ci == 6 || ci == 7 || ci == 8) && (|m_open));
        e.wbeat = (m_cnt > 0) && !m_rd;
        e.wmask = e.wbeat && m;
        if (!e.ill) begin
            if (ci == 1) m_open[b] = 1'b1;
            if (ci == 5) begin if (a[10]) m_open = '0; else m_open[b] = 1'b0; end
            if (ci == 8 && b == 2'b00) begin
                if (a[2:0] == 3'd1) m_blc = 1;
                if (a[2:0] == 3'd2) m_blc = 2;
                if (a[2:0] == 3'd3) m_blc = 4;
            end
        end
        if (!e.ill && (ci == 2 || ci == 3)) begin
            m_cnt = m_blc; m_rd = (ci == 2); m_ap = a[10]; m_bank = b;
        end else if (!e.ill && ci == 4) begin
            m_cnt = 0;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0 && m_ap) m_open[m_bank] = 1'b0;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic nop(input string tag);
        step(1'b1, 1'b0, K_NOP, 2'd0, 13'd0, 1'b0, tag);
    endtask

    task automatic nopdm(input logic m, input string tag);
        step(1'b1, 1'b0, K_NOP, 2'd0, 13'd0, m, tag);
    endtask

    // Apply reset and check that every output is zero.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cke = 1'b1; cs_n = 1'b1; dm = 1'b0;
        @(negedge clk);
        checks++;
        if ({cmd_o, bank_o, row_o, col_o, ap_o, pre_all_o, mr_ext_o, opcode_o,
             illegal_o, mr_err_o, wbeat_o, wmask_o} !== '0) begin
            bad++;
            $display("FAIL R13 reset state actual=%h expected=0",
                {cmd_o, bank_o, row_o, col_o, ap_o, pre_all_o, mr_ext_o, opcode_o,
                 illegal_o, mr_err_o, wbeat_o, wmask_o});
        end
        m_open = '0; m_blc = 1; m_cnt = 0; m_rd = 0; m_ap = 0; m_bank = '0;
        rst_n = 1'b1;
    endtask

    // Monitor: compare one expected word per clock after the edge.
    always @(posedge clk) begin
        exp_t  e;
        exp_t  act;
        string t;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            act = {cmd_o, bank_o, row_o, col_o, ap_o, pre_all_o, mr_ext_o, opcode_o,
                   illegal_o, mr_err_o, wbeat_o, wmask_o};
            checks++;
            if (act !== e) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", t, act, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 deselect equals NOP, whatever the strobes
        step(1'b1, 1'b1, 3'b000, 2'd3, 13'h1FFF, 1'b0, "R1");
        nop("R1");
        // R11 base mode set BL4; R7 extended and reserved targets
        step(1'b1, 1'b0, K_MRS, 2'd0, 13'h0032, 1'b0, "R11");
        step(1'b1, 1'b0, K_MRS, 2'd1, 13'h0ABC, 1'b0, "R7");
        step(1'b1, 1'b0, K_MRS, 2'd2, 13'h0003, 1'b0, "R7");
        step(1'b1, 1'b0, K_MRS, 2'd3, 13'h1001, 1'b0, "R7");
        // R2 activate; R10 second activate illegal
        step(1'b1, 1'b0, K_ACT, 2'd1, 13'h1ABC, 1'b0, "R2");
        step(1'b1, 1'b0, K_ACT, 2'd1, 13'h0123, 1'b0, "R10");
        // R3 column map with A11 set, A10 low; R8 legal stop in read
        step(1'b1, 1'b0, K_RD, 2'd1, 13'h0A5A, 1'b0, "R3");
        step(1'b1, 1'b0, K_BST, 2'd0, 13'h0000, 1'b0, "R8");
        step(1'b1, 1'b0, K_BST, 2'd0, 13'h0000, 1'b0, "R8");
        // R9 write burst with mask pattern; R8 stop in write illegal
        step(1'b1, 1'b0, K_WR, 2'd1, 13'h0155, 1'b0, "R9");
        nopdm(1'b1, "R9");
        step(1'b1, 1'b0, K_BST, 2'd0, 13'h0000, 1'b0, "R8");
        nopdm(1'b1, "R9");
        // R4 auto-precharge read; R8 stop illegal; R12 bank closes at end
        step(1'b1, 1'b0, K_RD, 2'd1, 13'h0403, 1'b0, "R4");
        step(1'b1, 1'b0, K_BST, 2'd0, 13'h0000, 1'b0, "R8");
        nop("R12");
        step(1'b1, 1'b0, K_RD, 2'd1, 13'h0000, 1'b0, "R12");
        // R4 A10 on a NOP gives no flag
        step(1'b1, 1'b0, K_NOP, 2'd0, 13'h0400, 1'b0, "R4");
        // R5 single and all-bank precharge
        step(1'b1, 1'b0, K_ACT, 2'd0, 13'h0011, 1'b0, "R10");
        step(1'b1, 1'b0, K_ACT, 2'd2, 13'h0022, 1'b0, "R10");
        step(1'b1, 1'b0, K_PRE, 2'd0, 13'h0000, 1'b0, "R5");
        step(1'b1, 1'b0, K_RD, 2'd0, 13'h0000, 1'b0, "R5");
        step(1'b1, 1'b0, K_RD, 2'd2, 13'h0007, 1'b0, "R5");
        nop("R5");
        step(1'b1, 1'b0, K_PRE, 2'd3, 13'h0400, 1'b0, "R5");
        step(1'b1, 1'b0, K_WR, 2'd2, 13'h0000, 1'b1, "R5");
        // R6 refresh, R13 refresh and mode set with a bank open
        step(1'b1, 1'b0, K_REF, 2'd0, 13'h0000, 1'b0, "R6");
        step(1'b1, 1'b0, K_ACT, 2'd3, 13'h0333, 1'b0, "R10");
        step(1'b1, 1'b0, K_REF, 2'd0, 13'h0000, 1'b0, "R13");
        step(1'b1, 1'b0, K_MRS, 2'd0, 13'h0003, 1'b0, "R13");
        step(1'b0, 1'b0, K_PRE, 2'd3, 13'h0000, 1'b0, "R6");
        step(1'b1, 1'b0, K_PRE, 2'd3, 13'h0000, 1'b0, "R5");
        step(1'b0, 1'b0, K_ACT, 2'd0, 13'h0001, 1'b0, "R6");
        step(1'b0, 1'b0, K_REF, 2'd0, 13'h0000, 1'b0, "R6");
        step(1'b0, 1'b0, K_NOP, 2'd0, 13'h0000, 1'b0, "R6");
        // R11 length 8, restart mid burst, reserved code keeps length
        step(1'b1, 1'b0, K_MRS, 2'd0, 13'h0003, 1'b0, "R11");
        step(1'b1, 1'b0, K_MRS, 2'd0, 13'h0007, 1'b0, "R11");
        step(1'b1, 1'b0, K_ACT, 2'd0, 13'h0ACE, 1'b0, "R11");
        step(1'b1, 1'b0, K_WR, 2'd0, 13'h0010, 1'b0, "R11");
        nopdm(1'b0, "R9");
        nopdm(1'b1, "R9");
        step(1'b1, 1'b0, K_WR, 2'd0, 13'h0420, 1'b1, "R11");
        for (int i = 0; i < 6; i++) nopdm(i[0], "R9");
        step(1'b1, 1'b0, K_RD, 2'd0, 13'h0000, 1'b0, "R12");
        // R13 reset closes an open bank
        step(1'b1, 1'b0, K_ACT, 2'd1, 13'h0005, 1'b0, "R10");
        nop("R13");
        do_reset();
        step(1'b1, 1'b0, K_RD, 2'd1, 13'h0000, 1'b0, "R13");
        nop("R1");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule